// File: doc/BRIEF.md
# Predriver Serial Status and Command Port

This block is the serial side of a six-channel low-side gate predriver. A host microcontroller reaches it through four wires: an active-low select, a serial clock, a data input and a data output. When the host pulls select low, the block freezes an eight-bit status word into a transmit register. Bit 7 of that word is the over-voltage flag of the supply, bit 6 is its under-voltage flag, and bits 5..0 are the load faults of channels 5..0. The word leaves on the data output with bit 7 first. In the same frame the host shifts in a command word, and each of its low six bits switches one gate on or off. The command is accepted only when the frame held exactly eight serial clocks.

The analog comparators are outside the block. Their results arrive as a logic vector that may change at any time. Each fault is held in a sticky flag while the port is idle. An active-low interrupt line reports that at least one flag is set. The next falling edge of select reads the flags and then reloads them from the present conditions, so a fault that has gone away is cleared and one that is still present keeps the interrupt low.

All serial inputs are assumed to be synchronous to the block clock and sampled by it. The serial clock must be at least four block clocks per half period. A frame runs through the states IDLE → SHIFT on the falling edge of select. It leaves SHIFT on the rising edge of select: to LOAD after exactly eight serial clocks, to DROP after any other count. Both LOAD and DROP return to IDLE on the next cycle. IDLE moves to SHIFT whenever select is seen low.

Top module: `psp_serial_port`

## Requirements
- R1: After reset the gate command register is 0, the interrupt line is high (1), the output-enable is 0 and the data output is 0.
- R2: The status word sent in a frame has the supply over-voltage flag at bit 7, the supply under-voltage flag at bit 6 and the fault of channel k at bit k, for k = 0..5. Input fault vector index 7 is over-voltage, index 6 is under-voltage and index k is channel k.
- R3: Within one block clock after select falls from IDLE, the output-enable is 1 and the data output shows status bit 7, before any serial clock edge.
- R4: Each falling edge of the serial clock in a frame moves the next lower status bit onto the data output, so bits 7 down to 0 appear in turn.
- R5: The data input is sampled on rising edges of the serial clock, with the first bit being the most significant. On commit, gate k takes command bit k for k = 0..5, and command bits 7 and 6 are ignored.
- R6: The command register changes only when select rises after exactly eight serial rising edges. A frame with fewer or more edges leaves it unchanged.
- R7: While select is high, a fault condition that is present for even one block clock sets its flag, and the flag stays set after the condition goes away.
- R8: The interrupt line is low while any flag is set. The falling edge of select reloads the flags from the present conditions, so the interrupt returns high if no condition remains and stays low if one persists.
- R9: While select is high, the output-enable is 0 and the data output is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock, idle low |
| sdi | input | 1 | Serial command data in |
| fault_raw | input | 8 | Live fault conditions: [7] over-voltage, [6] under-voltage, [5:0] channel load faults |
| sdo | output | 1 | Serial status data out, 0 when idle |
| sdo_oe | output | 1 | High while the data output is driven for a frame |
| fault_irq_n | output | 1 | Active-low interrupt, low while any fault flag is set |
| gate_cmd | output | 6 | Committed gate on/off command, one bit per channel |

## Verification
The frame table mixes several kinds of frames, so that each mistake shows up in a different way:
- Full eight-clock frames with distinct command patterns, including one whose top two bits are set, test bit order and the ignored bits.
- Short, long and zero-clock frames must leave the command register unchanged. This separates a correct count check from one that accepts any frame.
- Status patterns with supply and channel flags in different positions test the bit order.
- Faults that are removed before a frame, and faults that persist through it, separate clearing the interrupt from refreshing it.
- A single-cycle fault pulse while idle tests that a flag is sticky rather than a copy of the live level.

// File: rtl/psp_pkg.sv
package psp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LOAD  = 2'd2,
        ST_DROP  = 2'd3
    } psp_state_e;
endpackage

// File: rtl/psp_fault_latch.sv
module psp_fault_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic [W-1:0] raw,
    output logic [W-1:0] snap,
    output logic         irq_n
);
    logic [W-1:0] flag_q;

    // sticky flags; a capture reloads them from the live conditions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag_q <= '0;
        else if (capture) flag_q <= raw;
        else              flag_q <= flag_q | raw;
    end

    assign snap  = flag_q | raw;
    assign irq_n = ~(|flag_q);
endmodule

// File: rtl/psp_frame_fsm.sv
module psp_frame_fsm
    import psp_pkg::*;
#(
    parameter int W  = 8,
    parameter int CW = $clog2(W + 2)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sclk_rise,
    output psp_state_e st,
    output logic       capture,
    output logic       commit,
    output logic       active
);
    localparam logic [CW-1:0] FULL = CW'(W);
    localparam logic [CW-1:0] OVER = CW'(W + 1);

    psp_state_e    st_d;
    logic [CW-1:0] cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_d;
    end

    // rising-edge counter, saturating one past a full word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  cnt_q <= '0;
        else if (capture)                            cnt_q <= '0;
        else if (active && sclk_rise && cnt_q != OVER) cnt_q <= cnt_q + 1'b1;
    end

    // next state and outputs
    always_comb begin
        st_d    = st;
        capture = 1'b0;
        commit  = 1'b0;
        active  = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (!cs_n) begin
                    capture = 1'b1;
                    st_d    = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                active = 1'b1;
                if (cs_n) st_d = (cnt_q == FULL) ? ST_LOAD : ST_DROP;
            end
            ST_LOAD: begin
                commit = 1'b1;
                st_d   = ST_IDLE;
            end
            ST_DROP: begin
                st_d = ST_IDLE;
            end
        endcase
    end
endmodule

// File: rtl/psp_shift_core.sv
module psp_shift_core #(
    parameter int W   = 8,
    parameter int NCH = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           capture,
    input  logic [W-1:0]   snap,
    input  logic           rise,
    input  logic           fall,
    input  logic           sdi,
    output logic           tx_msb,
    output logic [NCH-1:0] rx
);
    logic [W-1:0]   tx_q;
    logic [NCH-1:0] rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       tx_q <= '0;
        else if (capture) tx_q <= snap;
        else if (fall)    tx_q <= {tx_q[W-2:0], 1'b0};
    end

    // only the last NCH bits of the frame are kept
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    rx_q <= '0;
        else if (rise) rx_q <= {rx_q[NCH-2:0], sdi};
    end

    assign tx_msb = tx_q[W-1];
    assign rx     = rx_q;
endmodule

// File: rtl/psp_serial_port.sv
module psp_serial_port
    import psp_pkg::*;
#(
    parameter int NCH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             sdi,
    input  logic [NCH+1:0]   fault_raw,
    output logic             sdo,
    output logic             sdo_oe,
    output logic             fault_irq_n,
    output logic [NCH-1:0]   gate_cmd
);
    localparam int W  = NCH + 2;
    localparam int CW = $clog2(W + 2);

    psp_state_e     st;
    logic           capture, commit, active;
    logic           sclk_d, sclk_rise, sclk_fall;
    logic [W-1:0]   snap;
    logic           tx_msb;
    logic [NCH-1:0] rx;
    logic [NCH-1:0] cmd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk;
    end

    assign sclk_rise = active &  sclk & ~sclk_d;
    assign sclk_fall = active & ~sclk &  sclk_d;

    psp_frame_fsm #(.W(W), .CW(CW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk_rise (sclk_rise),
        .st        (st),
        .capture   (capture),
        .commit    (commit),
        .active    (active)
    );

    psp_fault_latch #(.W(W)) u_flt (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .raw     (fault_raw),
        .snap    (snap),
        .irq_n   (fault_irq_n)
    );

    psp_shift_core #(.W(W), .NCH(NCH)) u_shf (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .snap    (snap),
        .rise    (sclk_rise),
        .fall    (sclk_fall),
        .sdi     (sdi),
        .tx_msb  (tx_msb),
        .rx      (rx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cmd_q <= '0;
        else if (commit) cmd_q <= rx;
    end

    assign gate_cmd = cmd_q;
    assign sdo_oe   = active;
    assign sdo      = active & tx_msb;
endmodule

// File: rtl/psp_serial_port_chk.sv
module psp_serial_port_chk
    import psp_pkg::*;
#(
    parameter int NCH = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             sdo,
    input logic             sdo_oe,
    input logic             fault_irq_n,
    input logic [NCH+1:0]   fault_raw,
    input logic [NCH-1:0]   gate_cmd,
    input psp_state_e       st
);
    AST_CMD_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_cmd != $past(gate_cmd)) |-> ($past(st) == ST_LOAD)); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> (!sdo_oe && !sdo)); // R9

    AST_FAULT_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (|fault_raw) |=> !fault_irq_n); // R8

    AST_FRAME_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && st == ST_IDLE) |=> sdo_oe); // R3

    AST_DRIVE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        sdo |-> sdo_oe); // R9
endmodule

bind psp_serial_port psp_serial_port_chk #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .sdo         (sdo),
    .sdo_oe      (sdo_oe),
    .fault_irq_n (fault_irq_n),
    .fault_raw   (fault_raw),
    .gate_cmd    (gate_cmd),
    .st          (st)
);

// File: tb/psp_serial_port_bench.sv
module psp_serial_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdi = 1'b0;
    logic [7:0] fault_raw = '0;
    logic       sdo, sdo_oe, fault_irq_n;
    logic [5:0] gate_cmd;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    psp_serial_port u_psp_serial_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .sclk        (sclk),
        .sdi         (sdi),
        .fault_raw   (fault_raw),
        .sdo         (sdo),
        .sdo_oe      (sdo_oe),
        .fault_irq_n (fault_irq_n),
        .gate_cmd    (gate_cmd)
    );

    // {raw[8], cmd[8], nclk[4], exp_status[8], exp_gate[6], exp_irq_n[1]}
    localparam logic [34:0] VEC [0:6] = '{
        {8'h00, 8'h2A, 4'd8, 8'h00, 6'h2A, 1'b1},  // R5 R6 plain commit
        {8'h81, 8'hFF, 4'd8, 8'h81, 6'h3F, 1'b0},  // R2 R8 persisting fault
        {8'h00, 8'h15, 4'd5, 8'h81, 6'h3F, 1'b1},  // R6 short frame, R8 clear
        {8'h00, 8'h00, 4'd9, 8'h00, 6'h3F, 1'b1},  // R6 long frame
        {8'h50, 8'h01, 4'd8, 8'h50, 6'h01, 1'b0},  // R2 under-voltage + ch4
        {8'h00, 8'h3C, 4'd0, 8'h50, 6'h01, 1'b1},  // R6 zero-clock frame
        {8'h00, 8'hC7, 4'd8, 8'h00, 6'h07, 1'b1}   // R5 top bits ignored
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // runs one frame; returns the sampled status bits and mask of valid bits
    task automatic frame(input logic [7:0] cmd, input int nclk,
                         output logic [7:0] got, output logic [7:0] mask);
        got  = '0;
        mask = '0;
        @(negedge clk);
        cs_n = 1'b0;
        wait_neg(2);
        check("R3 oe", 32'(sdo_oe), 32'd1);
        got[7]  = sdo;
        mask[7] = 1'b1;
        for (int i = 0; i < nclk; i++) begin
            sdi  = (i < 8) ? cmd[7-i] : 1'b0;
            sclk = 1'b1;
            wait_neg(4);
            sclk = 1'b0;
            wait_neg(4);
            if (i < 7) begin
                got[6-i]  = sdo;
                mask[6-i] = 1'b1;
            end
        end
        cs_n = 1'b1;
        sdi  = 1'b0;
        wait_neg(4);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] got, mask;
        wait_neg(3);
        // R1 reset state
        check("R1 gate", 32'(gate_cmd), 32'h0);
        check("R1 irq", 32'(fault_irq_n), 32'd1);
        check("R1 oe", 32'(sdo_oe), 32'd0);
        check("R1 sdo", 32'(sdo), 32'd0);
        rst_n = 1'b1;
        wait_neg(3);

        for (int v = 0; v < 7; v++) begin
            fault_raw = VEC[v][34:27];
            wait_neg(2);
            frame(VEC[v][26:19], int'(VEC[v][18:15]), got, mask);
            // R2 R4 status bits MSB first
            check("R2/R4 status", 32'(got & mask), 32'(VEC[v][14:7] & mask));
            check("R5/R6 gate", 32'(gate_cmd), 32'(VEC[v][6:1]));
            check("R8 irq", 32'(fault_irq_n), 32'(VEC[v][0]));
            // R9 idle output after frame
            check("R9 idle", 32'({sdo_oe, sdo}), 32'd0);
        end

        // R7 one-cycle fault pulse is held
        fault_raw = 8'h04;
        wait_neg(1);
        fault_raw = 8'h00;
        wait_neg(3);
        check("R7 sticky irq", 32'(fault_irq_n), 32'd0);
        frame(8'h3F, 8, got, mask);
        check("R7 captured flag", 32'(got), 32'h04);
        check("R8 irq cleared", 32'(fault_irq_n), 32'd1);
        check("R5 gate", 32'(gate_cmd), 32'h3F);

        // R8 persisting over-voltage refreshes the interrupt
        fault_raw = 8'h80;
        wait_neg(2);
        frame(8'h00, 8, got, mask);
        check("R8 refreshed irq", 32'(fault_irq_n), 32'd0);
        check("R2 ovr bit", 32'(got), 32'h80);
        fault_raw = 8'h00;
        frame(8'h00, 8, got, mask);
        check("R8 released irq", 32'(fault_irq_n), 32'd1);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule